// File: doc/BRIEF.md
# Configuration Row Writer over JTAG

This block is a JTAG master that loads the volatile configuration memory of a small programmable logic device through the device's test access port. It makes TCK from the system clock and drives TMS and TDI. The row data comes from an external synchronous row memory. The block computes the row address sent to the device itself.

A one-cycle `start` pulse runs the full load sequence:

- Bring the TAP to Test-Logic-Reset, then to Run-Test/Idle.
- Shift the configuration-enable instruction and idle for a fixed number of TCK cycles.
- Shift the write instruction.
- Send every row. Each row is one DR scan: the row's data bits, then that row's address bits.
- Shift the disable instruction and idle again.
- Load BYPASS without a DR scan and return the TAP to reset.

`busy` is high for the whole run. `done` pulses for one cycle when the run ends.

Rows are not sent in counting order. The device address for row number `r` is the 7-bit Gray code of `r`, written with its bits reversed. The row memory index runs one row ahead of the row being shifted, so the next row's data is already waiting.

Top module: `cfg_row_loader`

## Requirements
- R1: After reset, and whenever `busy` is low, the outputs are `tck`=0, `tms`=1, `tdi`=0 and `done`=0.
- R2: `start` is acted on only while `busy` is low. `busy` rises on the next clock and stays high until the run ends. A `start` pulse while `busy` is high has no effect on the TMS/TDI stream.
- R3: While busy, TCK has a period of 2*TCK_HALF system clocks. TMS and TDI change only in the cycle in which TCK falls.
- R4: A run opens with 5 TCK cycles at TMS=1 and then one cycle at TMS=0, with TDI=0.
- R5: Each instruction scan drives TMS as 1,1,0,0, then 8 instruction bits LSB first, then 1,0. TMS is 1 only on the last instruction bit. TDI is 0 outside the instruction bits.
- R6: The enable instruction (default 0xE8) is followed by exactly 800 TCK cycles at TMS=0. The write instruction (default 0xE6) comes next.
- R7: Each row scan opens with TMS 1,0,0 and TDI 0. Then 274 data bits follow at TMS=0. Data bit i is `row_data[i]`, and bit 0 goes first.
- R8: After the data bits come 7 address bits, LSB first. TMS is 1 only on the seventh address bit. Then TMS goes 1,0 back to Run-Test/Idle.
- R9: Row r carries address bitreverse7(r XOR (r>>1)). The sequence therefore begins 0x00, 0x40, 0x60, 0x20, 0x30, 0x70, 0x50, 0x10, 0x18.
- R10: `row_idx` rules:
  - It is 0 on the first cycle after a start.
  - Row r's data is taken while `row_idx`=r.
  - `row_idx` advances to r+1 once row r is captured.
  - It stays below NUM_ROWS.
  - `row_data` may follow `row_idx` by one system clock.
- R11: After the last row, the closing sequence runs:
  - the disable instruction (default 0xC0), then 100 TCK cycles at TMS=0;
  - BYPASS (0xFF);
  - 5 TCK cycles at TMS=1.
  After that, TCK stays low.
- R12: `done` is a one-cycle pulse in the cycle `busy` falls. A `start` in that same cycle begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load run (pulse) |
| row_data | input | ROW_BITS | Row memory read data for `row_idx` |
| row_idx | output | $clog2(NUM_ROWS) | Row memory read index |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG serial data to the device |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The end of one run and the request for the next one can land in the same system cycle: `done` is high, `busy` has just fallen, and `start` is sampled. The bench raises `start` in the very cycle it sees `done`. It then expects `busy` back high on the next clock, `row_idx` reset to 0, and a complete second TMS/TDI stream that matches its scoreboard bit for bit. A second `start`, raised in the middle of the first run, must leave that stream and the count of `done` pulses unchanged.

// File: rtl/cfg_row_loader.sv
module cfg_row_loader #(
  parameter int NUM_ROWS     = 98,
  parameter int ROW_BITS     = 274,
  parameter int ADDR_BITS    = 7,
  parameter int IR_BITS      = 8,
  parameter int TCK_HALF     = 1,
  parameter int RESET_LEN    = 5,
  parameter int ENABLE_HOLD  = 800,
  parameter int DISABLE_HOLD = 100,
  parameter logic [IR_BITS-1:0] IR_ENABLE  = 8'hE8,
  parameter logic [IR_BITS-1:0] IR_WRITE   = 8'hE6,
  parameter logic [IR_BITS-1:0] IR_DISABLE = 8'hC0,
  parameter logic [IR_BITS-1:0] IR_BYPASS  = '1,
  localparam int IDX_W = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ROW_BITS-1:0] row_data,
  output logic [IDX_W-1:0]    row_idx,
  output logic                tck,
  output logic                tms,
  output logic                tdi,
  output logic                busy,
  output logic                done
);
  localparam int IR_LEN  = 4 + IR_BITS + 2;
  localparam int DATA_LO = 3;
  localparam int ADDR_HI = DATA_LO + ROW_BITS + ADDR_BITS - 1;
  localparam int ROW_LEN = ADDR_HI + 3;
  localparam int BUF_W   = ROW_BITS + ADDR_BITS;
  localparam int M1 = (ENABLE_HOLD > DISABLE_HOLD) ? ENABLE_HOLD : DISABLE_HOLD;
  localparam int M2 = (ROW_LEN > IR_LEN) ? ROW_LEN : IR_LEN;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MAX_LEN = (M3 > RESET_LEN) ? M3 : RESET_LEN;
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam int DIV_W = (TCK_HALF > 1) ? $clog2(TCK_HALF) : 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TLR, ST_RTI, ST_IR_EN, ST_HOLD_EN, ST_IR_WR,
    ST_ROW, ST_IR_DIS, ST_HOLD_DIS, ST_IR_BYP, ST_TLR_END
  } st_t;

  st_t                st;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   len;
  logic [DIV_W-1:0]   div;
  logic [IDX_W-1:0]   row_cnt;
  logic [BUF_W-1:0]   sbuf;
  logic [IR_BITS-1:0] ir_code;
  logic [IR_BITS-1:0] ir_bits;
  logic               fall, last_step, tms_c, tdi_c;

  function automatic logic [ADDR_BITS-1:0] row_addr(input logic [IDX_W-1:0] r);
    logic [IDX_W:0] g;
    logic [ADDR_BITS-1:0] a;
    g = {1'b0, r} ^ ({1'b0, r} >> 1);
    a = '0;
    for (int k = 0; k < ADDR_BITS; k++)
      if (k <= IDX_W) a[ADDR_BITS-1-k] = g[k];
    return a;
  endfunction

  assign fall      = busy && tck && (div == DIV_W'(TCK_HALF - 1));
  assign last_step = (cnt == len - CNT_W'(1));
  assign ir_bits   = ir_code >> (cnt - CNT_W'(4));
  assign tms       = tms_c;
  assign tdi       = tdi_c;

  always_comb begin
    case (st)
      ST_TLR, ST_TLR_END:                    len = CNT_W'(RESET_LEN);
      ST_IR_EN, ST_IR_WR, ST_IR_DIS, ST_IR_BYP: len = CNT_W'(IR_LEN);
      ST_HOLD_EN:                            len = CNT_W'(ENABLE_HOLD);
      ST_HOLD_DIS:                           len = CNT_W'(DISABLE_HOLD);
      ST_ROW:                                len = CNT_W'(ROW_LEN);
      default:                               len = CNT_W'(1);
    endcase
    case (st)
      ST_IR_EN:  ir_code = IR_ENABLE;
      ST_IR_WR:  ir_code = IR_WRITE;
      ST_IR_DIS: ir_code = IR_DISABLE;
      default:   ir_code = IR_BYPASS;
    endcase
  end

  always_comb begin
    tms_c = 1'b0;
    tdi_c = 1'b0;
    case (st)
      ST_IDLE, ST_TLR, ST_TLR_END: tms_c = 1'b1;
      ST_IR_EN, ST_IR_WR, ST_IR_DIS, ST_IR_BYP: begin
        if (cnt < CNT_W'(2)) tms_c = 1'b1;
        else if (cnt < CNT_W'(4)) tms_c = 1'b0;
        else if (cnt < CNT_W'(4 + IR_BITS)) begin
          tdi_c = ir_bits[0];
          tms_c = (cnt == CNT_W'(4 + IR_BITS - 1));
        end else tms_c = (cnt == CNT_W'(IR_LEN - 2));
      end
      ST_ROW: begin
        tms_c = (cnt == '0) || (cnt == CNT_W'(ADDR_HI)) || (cnt == CNT_W'(ROW_LEN - 2));
        if (cnt >= CNT_W'(DATA_LO) && cnt <= CNT_W'(ADDR_HI)) tdi_c = sbuf[0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; div <= '0; tck <= 1'b0;
      busy <= 1'b0; done <= 1'b0;
      row_cnt <= '0; row_idx <= '0; sbuf <= '0;
    end else if (!busy) begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1; st <= ST_TLR; cnt <= '0; div <= '0; tck <= 1'b0;
        row_cnt <= '0; row_idx <= '0;
      end
    end else begin
      done <= 1'b0;
      if (div == DIV_W'(TCK_HALF - 1)) begin
        div <= '0;
        tck <= ~tck;
      end else div <= div + DIV_W'(1);
      if (fall) begin
        if (st == ST_ROW) begin
          if (cnt == '0) begin
            sbuf <= {row_addr(row_cnt), row_data};
            if (row_cnt != IDX_W'(NUM_ROWS - 1)) row_idx <= row_idx + IDX_W'(1);
          end else if (cnt >= CNT_W'(DATA_LO) && cnt < CNT_W'(ADDR_HI))
            sbuf <= sbuf >> 1;
        end
        if (last_step) begin
          cnt <= '0;
          case (st)
            ST_TLR:      st <= ST_RTI;
            ST_RTI:      st <= ST_IR_EN;
            ST_IR_EN:    st <= ST_HOLD_EN;
            ST_HOLD_EN:  st <= ST_IR_WR;
            ST_IR_WR:    st <= ST_ROW;
            ST_ROW:
              if (row_cnt == IDX_W'(NUM_ROWS - 1)) st <= ST_IR_DIS;
              else row_cnt <= row_cnt + IDX_W'(1);
            ST_IR_DIS:   st <= ST_HOLD_DIS;
            ST_HOLD_DIS: st <= ST_IR_BYP;
            ST_IR_BYP:   st <= ST_TLR_END;
            default: begin
              st <= ST_IDLE; busy <= 1'b0; done <= 1'b1;
            end
          endcase
        end else cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cfg_row_loader_chk.sv
module cfg_row_loader_chk #(
  parameter int NUM_ROWS = 98,
  parameter int IDX_W    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [IDX_W-1:0] row_idx,
  input logic             tck,
  input logic             tms,
  input logic             tdi,
  input logic             busy,
  input logic             done
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tck && tms && !tdi));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !($stable(tms) && $stable(tdi))) |-> $fell(tck));

  // R10
  row_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_idx < IDX_W'(NUM_ROWS));

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind cfg_row_loader cfg_row_loader_chk #(.NUM_ROWS(NUM_ROWS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .row_idx(row_idx),
  .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done)
);

// File: tb/test_cfg_row_loader.sv
module test_cfg_row_loader;
  localparam int NR = 98;
  localparam int RB = 274;
  localparam int IW = $clog2(NR);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [RB-1:0] row_data;
  logic [IW-1:0] row_idx;
  logic tck, tms, tdi, busy, done;

  int checks = 0, fails = 0, done_cnt = 0, r3_bad = 0, r3_seen = 0;
  bit [1:0] qb[$];
  string    qr[$];

  always #10 clk = ~clk;

  cfg_row_loader i_cfg_row_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .row_data(row_data),
    .row_idx(row_idx), .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done)
  );

  function automatic logic [RB-1:0] pat(input int r);
    logic [RB-1:0] p;
    for (int i = 0; i < RB; i++) begin
      if (r == 0) p[i] = 1'b1;
      else if (r == 1) p[i] = 1'b0;
      else p[i] = (((i * 5 + r * 3) % 7) < 3) ^ ((i % 97) == (r % 97));
    end
    return p;
  endfunction

  function automatic logic [6:0] exp_addr(input int r);
    logic [7:0] v;
    logic [6:0] a;
    v = r[7:0];
    for (int k = 0; k < 7; k++) a[6-k] = v[k] ^ v[k+1];
    return a;
  endfunction

  // row memory with one clock of read latency (R10)
  always @(posedge clk) row_data <= pat(int'(row_idx));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input bit m, input bit d, input string req);
    qb.push_back({m, d});
    qr.push_back(req);
  endtask

  task automatic push_ir(input logic [7:0] code, input string req);
    push(1, 0, req); push(1, 0, req); push(0, 0, req); push(0, 0, req);
    for (int i = 0; i < 8; i++) push(i == 7, code[i], req);
    push(1, 0, req); push(0, 0, req);
  endtask

  task automatic drive_run();
    logic [RB-1:0] p;
    logic [6:0] a;
    for (int i = 0; i < 5; i++) push(1, 0, "R4 open reset");
    push(0, 0, "R4 idle");
    push_ir(8'hE8, "R5 enable ir");
    for (int i = 0; i < 800; i++) push(0, 0, "R6 enable hold");
    push_ir(8'hE6, "R6 write ir");
    for (int r = 0; r < NR; r++) begin
      p = pat(r);
      a = exp_addr(r);
      push(1, 0, "R7 header"); push(0, 0, "R7 header"); push(0, 0, "R7 header");
      for (int i = 0; i < RB; i++) push(0, p[i], "R7 data");
      for (int i = 0; i < 7; i++) push(i == 6, a[i], "R9 address");
      push(1, 0, "R8 trailer"); push(0, 0, "R8 trailer");
    end
    push_ir(8'hC0, "R11 disable ir");
    for (int i = 0; i < 100; i++) push(0, 0, "R11 disable hold");
    push_ir(8'hFF, "R11 bypass ir");
    for (int i = 0; i < 5; i++) push(1, 0, "R11 close reset");
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge tck);
    #1;
    if (qb.size() == 0) chk(0, "R2 unexpected tck", {30'd0, tms, tdi}, 32'd0);
    else begin
      bit [1:0] b;
      string r;
      b = qb.pop_front();
      r = qr.pop_front();
      chk({tms, tdi} == b, r, {30'd0, tms, tdi}, {30'd0, b});
    end
  end

  // R3 timing monitor and done counter
  logic pt = 1'b0, pm = 1'b1, pd = 1'b0, pb = 1'b0;
  int since = 0;
  bit have = 0;
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (busy && pb) begin
      if ((tms != pm || tdi != pd) && !(pt && !tck)) r3_bad++;
      since++;
      if (tck && !pt) begin
        if (have && since != 2) r3_bad++;
        have = 1; since = 0; r3_seen++;
      end
    end else begin
      have = 0; since = 0;
    end
    pt = tck; pm = tms; pd = tdi; pb = busy;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle busy/done", {busy, done}, 0);
    chk(!tck && tms && !tdi, "R1 idle lines", {tck, tms, tdi}, 3'b010);

    drive_run();
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy, "R2 busy after start", busy, 1);
    chk(row_idx == 0, "R10 index at start", row_idx, 0);

    repeat (5000) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy, "R2 start while busy", busy, 1);

    while (!done) @(negedge clk);
    chk(!busy && !tck && tms, "R11 lines at end", {busy, tck, tms}, 3'b001);
    chk(row_idx == IW'(NR - 1), "R10 index at end", row_idx, NR - 1);
    chk(qb.size() == 0, "R11 stream complete", qb.size(), 0);
    drive_run();
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!done, "R12 done one cycle", done, 0);
    chk(busy, "R12 start in done cycle", busy, 1);
    chk(row_idx == 0, "R10 index restart", row_idx, 0);

    while (!done) @(negedge clk);
    chk(qb.size() == 0, "R11 second stream complete", qb.size(), 0);
    @(negedge clk);
    #1;
    chk(done_cnt == 2, "R12 done pulses", done_cnt, 2);
    chk(!done && !busy, "R1 idle after run", {done, busy}, 0);
    chk(r3_bad == 0 && r3_seen > 1000, "R3 tck period and edge", r3_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule